// File: doc/BRIEF.md
# Two-way set-associative write-back cache

This block sits between a processor that issues single-word reads and writes and a slower word-wide main memory. The 12-bit word address is split into a set index and a tag. The two stored tags of the indexed set are compared with the request tag in parallel. A match with a valid way is served without any memory traffic. A miss picks a victim way in the set. If that victim holds a modified word, the word is first written back to memory. The requested word is then fetched, installed and returned.

Writes follow a write-back, write-allocate policy. A write that hits updates the cached word and marks it modified. A write that misses first fetches the old word, then places the new data over it and marks the way modified. Each set keeps one bit naming its most recently used way, and this bit drives the choice of victim.

The processor side accepts a request whenever `cpu_ready` is high and reports completion with a one-cycle `cpu_done` pulse. The memory side holds a request until the memory acknowledges it.

Top module: `cwb_cache`

## Requirements
- R1: After reset, `cpu_ready` is 1 and both `mem_req` and `cpu_done` are 0. Every way is invalid, so the first access to any set misses and produces no write to memory.
- R2: The low 8 address bits select one of 256 sets, and the high 4 bits are the tag. Two addresses with the same low 8 bits and different tags can both be resident at the same time.
- R3: A hit makes no memory request. `cpu_done` rises in the cycle after the request is accepted, and for a read `cpu_rdata` holds the word at that point.
- R4: A read miss makes exactly one memory read, at the request address. It returns the fetched word on `cpu_rdata` with `cpu_done`, and installs the word so that the next access to it hits.
- R5: A write to a resident word updates it and marks the way modified. No memory write happens until that way is evicted.
- R6: Evicting a modified way first makes one memory write. The write address is {stored tag, index}, and the write carries the stored word. The refill read follows the write.
- R7: Evicting an invalid way, or a valid way that was not modified, makes no memory write.
- R8: The victim is the first invalid way of the set, with way 0 ahead of way 1. If both ways are valid, the victim is the way not used most recently. Both hits and refills count as a use.
- R9: A write miss reads the old word from memory, then installs the written data in its place and marks the way modified.
- R10: While a miss is being handled, `cpu_ready` is 0. Once `mem_req` is raised, it stays high with a steady address, direction and write data until `mem_ack`.
- R11: A read always returns the data of the most recent write to that address, or the memory's initial content if the address was never written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 12 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_done | output | 1 | One-cycle pulse when a request completes |
| cpu_rdata | output | 16 | Read data, valid with `cpu_done` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write (write-back), 0 = read (refill) |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Write-back data |
| mem_ack | input | 1 | One-cycle acknowledge of the current memory request |
| mem_rdata | input | 16 | Refill data, sampled with `mem_ack` |

## Verification
The bench builds the block with its default parameters: a 12-bit address, 16-bit data and an 8-bit index. With these values, every one of the 16 tags can be aimed at a single set. The random phase confines its addresses to four sets and draws the tag freely, so evictions of modified ways, evictions of clean ways and refills of invalid ways all happen often. The memory model varies its acknowledge delay, which exercises the rule that requests stay steady while the memory has not yet answered.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam int WAYS  = 2;
  localparam int WAY_W = $clog2(WAYS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_RESP  = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/cwb_store.sv
module cwb_store
  import cwb_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [IDX_W-1:0]               idx,
  input  logic                           wr_en,
  input  logic [WAY_W-1:0]               wr_way,
  input  logic [TAG_W-1:0]               wr_tag,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           wr_dirty,
  input  logic                           touch_en,
  input  logic [WAY_W-1:0]               touch_way,
  output logic [WAYS-1:0][TAG_W-1:0]     rd_tag,
  output logic [WAYS-1:0][DATA_W-1:0]    rd_data,
  output logic [WAYS-1:0]                rd_valid,
  output logic [WAYS-1:0]                rd_dirty,
  output logic [WAY_W-1:0]               rd_mru
);
  localparam int SETS = 1 << IDX_W;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tag_mem [SETS];
    logic [DATA_W-1:0] dat_mem [SETS];
    logic [SETS-1:0]   vld_q;
    logic [SETS-1:0]   drt_q;
    logic              sel;

    assign sel = wr_en && (int'(wr_way) == w);

    // payload arrays carry no reset; the valid bit guards them
    always_ff @(posedge clk) begin
      if (sel) begin
        tag_mem[idx] <= wr_tag;
        dat_mem[idx] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (sel) begin
        vld_q[idx] <= 1'b1;
        drt_q[idx] <= wr_dirty;
      end
    end

    assign rd_tag[w]   = tag_mem[idx];
    assign rd_data[w]  = dat_mem[idx];
    assign rd_valid[w] = vld_q[idx];
    assign rd_dirty[w] = drt_q[idx];
  end

  logic [SETS-1:0][WAY_W-1:0] mru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mru_q <= '0;
    end else if (touch_en) begin
      mru_q[idx] <= touch_way;
    end
  end

  assign rd_mru = mru_q[idx];

  // R5: a modified way is always a valid way
  a_r5_dirty_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dirty & ~rd_valid) == '0);
endmodule

// File: rtl/cwb_match.sv
module cwb_match
  import cwb_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic [TAG_W-1:0]           req_tag,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0]            way_dirty,
  input  logic [WAY_W-1:0]           mru,
  output logic [WAYS-1:0]            match_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic [WAY_W-1:0]           victim_way,
  output logic                       victim_dirty
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
  end

  assign hit     = |match_vec;
  assign hit_way = match_vec[1];

  always_comb begin
    if (!way_valid[0])      victim_way = 1'b0;
    else if (!way_valid[1]) victim_way = 1'b1;
    else                    victim_way = ~mru;
  end

  assign victim_dirty = way_valid[victim_way] && way_dirty[victim_way];
endmodule

// File: rtl/cwb_ctrl.sv
module cwb_ctrl
  import cwb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cpu_req,
  input  logic                           cpu_we,
  input  logic [ADDR_W-1:0]              cpu_addr,
  input  logic [DATA_W-1:0]              cpu_wdata,
  output logic                           cpu_ready,
  output logic                           cpu_done,
  output logic [DATA_W-1:0]              cpu_rdata,
  output logic [IDX_W-1:0]               look_idx,
  output logic [ADDR_W-IDX_W-1:0]        look_tag,
  input  logic                           hit,
  input  logic [WAY_W-1:0]               hit_way,
  input  logic [WAY_W-1:0]               victim_way,
  input  logic                           victim_dirty,
  input  logic [WAYS-1:0][ADDR_W-IDX_W-1:0] way_tag,
  input  logic [WAYS-1:0][DATA_W-1:0]    way_data,
  output logic                           st_wr_en,
  output logic [WAY_W-1:0]               st_wr_way,
  output logic [ADDR_W-IDX_W-1:0]        st_wr_tag,
  output logic [DATA_W-1:0]              st_wr_data,
  output logic                           st_wr_dirty,
  output logic                           st_touch_en,
  output logic [WAY_W-1:0]               st_touch_way,
  output logic                           mem_req,
  output logic                           mem_we,
  output logic [ADDR_W-1:0]              mem_addr,
  output logic [DATA_W-1:0]              mem_wdata,
  input  logic                           mem_ack,
  input  logic [DATA_W-1:0]              mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_state_e          state_q, state_n;
  logic [ADDR_W-1:0]   req_addr_q;
  logic                req_we_q;
  logic [DATA_W-1:0]   req_wdata_q;
  logic [WAY_W-1:0]    victim_q, victim_n;
  logic [DATA_W-1:0]   rdata_q, rdata_n;
  logic                done_q, done_n;
  logic                take_miss;
  logic                rdata_en;

  logic [IDX_W-1:0]    req_idx;
  logic [TAG_W-1:0]    req_tag;

  assign req_idx = req_addr_q[IDX_W-1:0];
  assign req_tag = req_addr_q[ADDR_W-1:IDX_W];

  always_comb begin
    if (state_q == ST_IDLE) begin
      look_idx = cpu_addr[IDX_W-1:0];
      look_tag = cpu_addr[ADDR_W-1:IDX_W];
    end else begin
      look_idx = req_idx;
      look_tag = req_tag;
    end
  end

  always_comb begin
    state_n      = state_q;
    victim_n     = victim_q;
    rdata_n      = rdata_q;
    rdata_en     = 1'b0;
    done_n       = 1'b0;
    take_miss    = 1'b0;
    cpu_ready    = 1'b0;
    st_wr_en     = 1'b0;
    st_wr_way    = hit_way;
    st_wr_tag    = way_tag[hit_way];
    st_wr_data   = cpu_wdata;
    st_wr_dirty  = 1'b0;
    st_touch_en  = 1'b0;
    st_touch_way = hit_way;
    mem_req      = 1'b0;
    mem_we       = 1'b0;
    mem_addr     = req_addr_q;
    mem_wdata    = way_data[victim_q];

    unique case (state_q)
      ST_IDLE: begin
        cpu_ready = 1'b1;
        if (cpu_req) begin
          if (hit) begin
            st_touch_en = 1'b1;
            done_n      = 1'b1;
            rdata_n     = way_data[hit_way];
            rdata_en    = 1'b1;
            if (cpu_we) begin
              st_wr_en    = 1'b1;
              st_wr_dirty = 1'b1;
            end
          end else begin
            take_miss = 1'b1;
            victim_n  = victim_way;
            state_n   = victim_dirty ? ST_WBACK : ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {way_tag[victim_q], req_idx};
        if (mem_ack) state_n = ST_FILL;
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          st_wr_en     = 1'b1;
          st_wr_way    = victim_q;
          st_wr_tag    = req_tag;
          st_wr_data   = req_we_q ? req_wdata_q : mem_rdata;
          st_wr_dirty  = req_we_q;
          st_touch_en  = 1'b1;
          st_touch_way = victim_q;
          rdata_n      = mem_rdata;
          rdata_en     = 1'b1;
          state_n      = ST_RESP;
        end
      end
      ST_RESP: begin
        done_n  = 1'b1;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      victim_q <= '0;
    end else begin
      state_q  <= state_n;
      done_q   <= done_n;
      victim_q <= victim_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr_q  <= '0;
      req_we_q    <= 1'b0;
      req_wdata_q <= '0;
    end else if (take_miss) begin
      req_addr_q  <= cpu_addr;
      req_we_q    <= cpu_we;
      req_wdata_q <= cpu_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_n;
  end

  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;

  // R10: an outstanding memory request keeps its fields until acknowledged
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && (!mem_we || $stable(mem_wdata))));

  // R10: the processor is held off while memory is busy
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  // R6: an acknowledged write-back is followed by the refill read
  a_r6_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  // R4: an acknowledged refill leads to completion two cycles later
  a_r4_fill_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> ##1 cpu_done);
endmodule

// File: rtl/cwb_cache.sv
module cwb_cache
  import cwb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]               look_idx;
  logic [TAG_W-1:0]               look_tag;
  logic [WAYS-1:0][TAG_W-1:0]     way_tag;
  logic [WAYS-1:0][DATA_W-1:0]    way_data;
  logic [WAYS-1:0]                way_valid;
  logic [WAYS-1:0]                way_dirty;
  logic [WAY_W-1:0]               set_mru;
  logic [WAYS-1:0]                match_vec;
  logic                           hit;
  logic [WAY_W-1:0]               hit_way;
  logic [WAY_W-1:0]               victim_way;
  logic                           victim_dirty;
  logic                           st_wr_en;
  logic [WAY_W-1:0]               st_wr_way;
  logic [TAG_W-1:0]               st_wr_tag;
  logic [DATA_W-1:0]              st_wr_data;
  logic                           st_wr_dirty;
  logic                           st_touch_en;
  logic [WAY_W-1:0]               st_touch_way;

  cwb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (look_idx),
    .wr_en     (st_wr_en),
    .wr_way    (st_wr_way),
    .wr_tag    (st_wr_tag),
    .wr_data   (st_wr_data),
    .wr_dirty  (st_wr_dirty),
    .touch_en  (st_touch_en),
    .touch_way (st_touch_way),
    .rd_tag    (way_tag),
    .rd_data   (way_data),
    .rd_valid  (way_valid),
    .rd_dirty  (way_dirty),
    .rd_mru    (set_mru)
  );

  cwb_match #(.TAG_W(TAG_W)) u_match (
    .req_tag      (look_tag),
    .way_tag      (way_tag),
    .way_valid    (way_valid),
    .way_dirty    (way_dirty),
    .mru          (set_mru),
    .match_vec    (match_vec),
    .hit          (hit),
    .hit_way      (hit_way),
    .victim_way   (victim_way),
    .victim_dirty (victim_dirty)
  );

  cwb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_ready    (cpu_ready),
    .cpu_done     (cpu_done),
    .cpu_rdata    (cpu_rdata),
    .look_idx     (look_idx),
    .look_tag     (look_tag),
    .hit          (hit),
    .hit_way      (hit_way),
    .victim_way   (victim_way),
    .victim_dirty (victim_dirty),
    .way_tag      (way_tag),
    .way_data     (way_data),
    .st_wr_en     (st_wr_en),
    .st_wr_way    (st_wr_way),
    .st_wr_tag    (st_wr_tag),
    .st_wr_data   (st_wr_data),
    .st_wr_dirty  (st_wr_dirty),
    .st_touch_en  (st_touch_en),
    .st_touch_way (st_touch_way),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata)
  );

  // R2: a tag is never resident in both ways of one set
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

// File: tb/sim_cwb_cache.sv
module sim_cwb_cache;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_ready, cpu_done;
  logic [15:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cwb_cache u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // backing memory and architectural shadow
  logic [15:0] bmem [4096];
  logic [15:0] shadow [4096];
  int          rd_cnt = 0, wr_cnt = 0, ops = 0, lat = 0;
  logic        first_we = 1'b0;
  logic [11:0] last_wa = '0, last_ra = '0;
  logic [15:0] last_wd = '0;

  assign mem_rdata = bmem[mem_addr];

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (lat == 0) begin
        mem_ack <= 1'b1;
        if (ops == 0) first_we <= mem_we;
        ops <= ops + 1;
        if (mem_we) begin
          bmem[mem_addr] <= mem_wdata;
          wr_cnt  <= wr_cnt + 1;
          last_wa <= mem_addr;
          last_wd <= mem_wdata;
        end else begin
          rd_cnt  <= rd_cnt + 1;
          last_ra <= mem_addr;
        end
        lat <= int'($urandom % 3);
      end else begin
        lat <= lat - 1;
      end
    end
  end

  // cache reference state built from the requirements
  logic [3:0] m_tag [256][2];
  bit         m_val [256][2];
  bit         m_drt [256][2];
  bit         m_mru [256];

  int n_checks = 0, n_fail = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [11:0] a,
                        input logic [15:0] d, input string rq);
    logic [7:0]  ix;
    logic [3:0]  tg;
    int          hw, vic, cyc, rd0, wr0;
    bit          exp_wb;
    logic [11:0] exp_wa;
    logic [15:0] exp_rd;
    ix = a[7:0];
    tg = a[11:8];
    hw = -1;
    for (int w = 0; w < 2; w++) if (m_val[ix][w] && m_tag[ix][w] == tg) hw = w;
    if (!m_val[ix][0])      vic = 0;
    else if (!m_val[ix][1]) vic = 1;
    else                    vic = m_mru[ix] ? 0 : 1;
    exp_wb = (hw < 0) && m_val[ix][vic] && m_drt[ix][vic];
    exp_wa = {m_tag[ix][vic], ix};
    exp_rd = shadow[a];

    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt; ops = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cpu_req = 1'b0;
      cyc++;
      if (!cpu_done && cpu_ready)
        check(1'b0, "R10", "ready high during miss", 1, 0);
    end while (!cpu_done);

    if (hw >= 0) begin
      check(cyc == 1, rq, "hit latency", cyc, 1);
      check(rd_cnt == rd0 && wr_cnt == wr0, rq, "hit memory traffic",
            (rd_cnt - rd0) + (wr_cnt - wr0), 0);
    end else begin
      check(rd_cnt - rd0 == 1, rq, "miss reads", rd_cnt - rd0, 1);
      check(last_ra == a, rq, "refill address", int'(last_ra), int'(a));
      check(wr_cnt - wr0 == int'(exp_wb), rq, "write-back count",
            wr_cnt - wr0, int'(exp_wb));
      if (exp_wb) begin
        check(last_wa == exp_wa, rq, "write-back address", int'(last_wa), int'(exp_wa));
        check(last_wd == shadow[exp_wa], rq, "write-back data",
              int'(last_wd), int'(shadow[exp_wa]));
        check(first_we == 1'b1, rq, "write-back before refill", int'(first_we), 1);
      end
    end
    if (!we) check(cpu_rdata == exp_rd, rq, "read data", int'(cpu_rdata), int'(exp_rd));

    if (hw >= 0) begin
      m_drt[ix][hw] = m_drt[ix][hw] | we;
      m_mru[ix] = hw[0];
    end else begin
      m_tag[ix][vic] = tg;
      m_val[ix][vic] = 1'b1;
      m_drt[ix][vic] = we;
      m_mru[ix] = vic[0];
    end
    if (we) shadow[a] = d;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) begin
      bmem[i]   = 16'(i * 37) ^ 16'h5a5a;
      shadow[i] = bmem[i];
    end
    for (int s = 0; s < 256; s++) begin
      m_val[s][0] = 0; m_val[s][1] = 0;
      m_drt[s][0] = 0; m_drt[s][1] = 0;
      m_tag[s][0] = '0; m_tag[s][1] = '0;
      m_mru[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cpu_ready == 1'b1, "R1", "ready after reset", int'(cpu_ready), 1);
    check(mem_req == 1'b0, "R1", "mem_req after reset", int'(mem_req), 0);
    check(cpu_done == 1'b0, "R1", "done after reset", int'(cpu_done), 0);
    access(1'b0, 12'h123, 16'h0, "R1");
    // R2 R4 R8: two tags in one set, invalid way taken first
    access(1'b0, 12'h045, 16'h0, "R4");
    access(1'b0, 12'h145, 16'h0, "R8");
    access(1'b0, 12'h045, 16'h0, "R2");
    access(1'b0, 12'h145, 16'h0, "R3");
    // R8: make 0x045 most recent, new tag must evict 0x145
    access(1'b0, 12'h045, 16'h0, "R3");
    access(1'b0, 12'h245, 16'h0, "R8");
    access(1'b0, 12'h045, 16'h0, "R8");
    access(1'b0, 12'h145, 16'h0, "R8");
    // R5 R6 R7: dirty a way, then evict it and a clean one
    access(1'b1, 12'h045, 16'hbeef, "R5");
    access(1'b0, 12'h345, 16'h0, "R7");
    access(1'b0, 12'h445, 16'h0, "R6");
    access(1'b0, 12'h045, 16'h0, "R11");
    // R9: write miss then read back and force eviction
    access(1'b1, 12'h777, 16'hc0de, "R9");
    access(1'b0, 12'h777, 16'h0, "R9");
    access(1'b0, 12'h877, 16'h0, "R9");
    access(1'b0, 12'h977, 16'h0, "R6");
    access(1'b0, 12'h777, 16'h0, "R11");
    // R11 random mix over four conflicting sets
    for (int k = 0; k < 3000; k++) begin
      logic [11:0] ra;
      ra = {4'($urandom), 8'h20 + 8'($urandom % 4)};
      if (k % 10 == 0) ra = 12'($urandom);
      access(1'($urandom), ra, 16'($urandom), "R11");
    end
    summary();
  end
endmodule